// File: doc/BRIEF.md
# Keypad Level-Interrupt Controller

This block watches one asynchronous key line and compares it against an active level chosen by software. When the synchronized key matches that level, a sticky event flag is raised. The flag drives an interrupt request unless software masks it, and only while an externally supplied global keyboard enable is on. Reading the status register returns the flag and clears it in the same access. Because detection is by level, a key still held at the active level raises the flag again one clock after the clearing read.

A second path serves power management. When the wake enable bit is set, the raw key line, compared combinationally against the selected level, drives a wake output with no clock in the path. This lets the core leave idle or power-down while every clock is stopped. A short glitch on the key line can therefore wake the core without any event being recorded.

Software reaches the block through a byte-wide register bus with two addresses. The flag is held by a two-state machine. In state FLG_IDLE the flag is clear. Transition ARM moves to FLG_PEND when the synchronized key matches and no status read is under way. In FLG_PEND the flag is set, and transition HOLD keeps it there while no status read occurs. Transition CLEAR returns to FLG_IDLE on any status read. A status read in FLG_IDLE keeps the machine in FLG_IDLE, even when the key matches in that cycle.

Top module: `kpd_irq_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read 0x00, and `irq` and `wake` are 0. The synchronizer flops reset to 1, which is the inactive level for the reset polarity of 0.
- R2: Control bit 4 selects the active level. With 0 a low key is active, and with 1 a high key is active.
- R3: The flag (status bit 0) is set at the third rising edge after the key reaches the active level: two synchronizer stages, then the flag register. The flag stays set after the key leaves the active level, until it is cleared by a status read.
- R4: A read of address 1 (`rd_en`=1) returns the current flag and clears it at that clock edge. A status read takes priority over a new match in the same cycle. If the synchronized key is still active, the flag is set again at the next edge.
- R5: `irq` is 1 exactly when the flag is set, control bit 0 (the mask) is 0 and `glb_en` is 1. It follows these inputs in the same cycle. The flag still records events while the mask is 1.
- R6: `wake` is 1 exactly when status bit 2 (the wake enable) is 1 and the raw `key_in` equals the selected level. This is combinational, with no clock involved.
- R7: Status bit 0 is read-only, and a write of address 1 changes only bit 2. Only bits 4 and 0 of the control register and bits 2 and 0 of the status register read as anything other than 0.
- R8: A write of address 0 updates the polarity (bit 4) and the mask (bit 0). `rdata` always shows the register selected by `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_in | input | 1 | Raw asynchronous key line |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag at address 1) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected register |
| glb_en | input | 1 | Global keyboard interrupt enable from outside |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Asynchronous wake request |

## Verification
A key change shows up in the flag, and therefore in `irq` and the status read data, at the third rising edge after it is applied. A clearing read acts at the edge that ends the read cycle. `irq` and `rdata` follow the mask, enable and address inputs within the same cycle, and `wake` follows `key_in` with no clock at all. The bench drives every input just after a falling edge and compares `rdata`, `irq` and `wake` shortly after that edge against a behavioural model. The model advances its two-entry synchronizer history and its flag only at each rising edge, so each result is checked in exactly the cycle it is due.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    localparam int CTRL_ADDR = 0;
    localparam int STAT_ADDR = 1;
    localparam int POL_BIT   = 4;
    localparam int MASK_BIT  = 0;
    localparam int FLAG_BIT  = 0;
    localparam int WEN_BIT   = 2;

    typedef enum logic [0:0] {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_state_e;
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/kpd_regs.sv
module kpd_regs
    import kpd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic              pol,
    output logic              mask,
    output logic              wen,
    output logic              stat_rd,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic pol_q, mask_q, wen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            mask_q <= 1'b0;
            wen_q  <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CTRL) begin
                pol_q  <= wdata[POL_BIT];
                mask_q <= wdata[MASK_BIT];
            end else if (addr == A_STAT) begin
                wen_q  <= wdata[WEN_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[POL_BIT]  = pol_q;
            rdata[MASK_BIT] = mask_q;
        end else if (addr == A_STAT) begin
            rdata[WEN_BIT]  = wen_q;
            rdata[FLAG_BIT] = flag;
        end
    end

    assign stat_rd = rd_en && (addr == A_STAT);
    assign pol     = pol_q;
    assign mask    = mask_q;
    assign wen     = wen_q;
endmodule

// File: rtl/kpd_flag_fsm.sv
module kpd_flag_fsm
    import kpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr,
    output logic flag
);
    flg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (match && !clr) state_d = FLG_PEND;   // ARM
            FLG_PEND: if (clr)           state_d = FLG_IDLE;   // CLEAR, else HOLD
            default:                     state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_PEND: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/kpd_wake.sv
module kpd_wake (
    input  logic key_raw,
    input  logic pol,
    input  logic wen,
    output logic wake
);
    assign wake = wen & ~(key_raw ^ pol);
endmodule

// File: rtl/kpd_irq_ctrl.sv
module kpd_irq_ctrl
    import kpd_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              glb_en,
    output logic              irq,
    output logic              wake
);
    logic key_sync, pol_q, mask_q, wen_q, stat_rd, flag, key_match;

    kpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(key_in), .q_sync(key_sync)
    );

    kpd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .flag(flag), .pol(pol_q),
        .mask(mask_q), .wen(wen_q), .stat_rd(stat_rd), .rdata(rdata)
    );

    assign key_match = (key_sync == pol_q);

    kpd_flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .match(key_match), .clr(stat_rd), .flag(flag)
    );

    kpd_wake u_wake (
        .key_raw(key_in), .pol(pol_q), .wen(wen_q), .wake(wake)
    );

    assign irq = flag & ~mask_q & glb_en;
endmodule

// File: rtl/kpd_irq_ctrl_chk.sv
module kpd_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic key_sync,
    input logic pol,
    input logic mask,
    input logic wen,
    input logic stat_rd,
    input logic flag,
    input logic glb_en,
    input logic irq,
    input logic wake
);
    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!flag && !pol && !mask && !wen));

    // R3
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_sync == pol) && !stat_rd |=> flag);

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !stat_rd |=> flag);

    // R4
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !flag);

    // R5
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> glb_en);

    // R5
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq);

    // R6
    wake_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> wen);
endmodule

bind kpd_irq_ctrl kpd_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .key_sync(key_sync), .pol(pol_q),
    .mask(mask_q), .wen(wen_q), .stat_rd(stat_rd), .flag(flag),
    .glb_en(glb_en), .irq(irq), .wake(wake)
);

// File: tb/kpd_irq_ctrl_test.sv
module kpd_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_in = 1'b1;
    logic [0:0] reg_addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       glb_en = 1'b0;
    logic       irq, wake;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    bit m_s1 = 1, m_s2 = 1, m_flag = 0, m_pol = 0, m_mask = 0, m_wen = 0;

    always #10 clk = ~clk;

    kpd_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .reg_addr(reg_addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .glb_en(glb_en), .irq(irq), .wake(wake)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // op: 0 idle, 1 read, 2 write
    task automatic cyc(input bit k, input bit g, input int op, input bit a,
                       input logic [7:0] d, input string req);
        logic [7:0] exp_rd;
        bit stat_read, nf;
        @(negedge clk);
        key_in = k; glb_en = g; rd_en = (op == 1); wr_en = (op == 2);
        reg_addr = a; wdata = d;
        #2;
        exp_rd = a ? {5'b0, m_wen, 1'b0, m_flag} : {3'b0, m_pol, 3'b0, m_mask};
        chk(req, "rdata", rdata, exp_rd);
        chk(req, "irq", irq, m_flag & ~m_mask & g);
        chk(req, "wake", wake, m_wen & (k == m_pol));
        @(posedge clk);
        stat_read = (op == 1) && a;
        nf = stat_read ? 1'b0 : (m_flag | (m_s2 == m_pol));
        m_s2 = m_s1; m_s1 = k;
        if (op == 2) begin
            if (!a) begin m_pol = d[4]; m_mask = d[0]; end
            else    m_wen = d[2];
        end
        m_flag = nf;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(1, 0, 0, 0, 8'h00, "R1");
        cyc(1, 0, 0, 1, 8'h00, "R1");
        // R8 control writes and readback
        cyc(1, 0, 2, 0, 8'h01, "R8");
        cyc(1, 0, 0, 0, 8'h00, "R8");
        cyc(0, 0, 2, 0, 8'h10, "R8");
        cyc(0, 0, 0, 0, 8'h00, "R8");
        // R7 unused bits and read-only flag
        cyc(0, 0, 2, 0, 8'hFF, "R7");
        cyc(0, 0, 0, 0, 8'h00, "R7");
        cyc(0, 0, 2, 1, 8'hFF, "R7");
        cyc(0, 0, 0, 1, 8'h00, "R7");
        cyc(0, 0, 2, 1, 8'h01, "R7");
        cyc(0, 0, 0, 1, 8'h00, "R7");
        // R3 low-active event, latency and stickiness
        cyc(1, 1, 2, 0, 8'h00, "R3");
        repeat (4) cyc(1, 1, 1, 1, 8'h00, "R3");
        cyc(0, 1, 0, 1, 8'h00, "R3");
        repeat (6) cyc(1, 1, 0, 1, 8'h00, "R3");
        // R4 clear on read, re-arm while held
        cyc(1, 1, 1, 1, 8'h00, "R4");
        cyc(1, 1, 0, 1, 8'h00, "R4");
        repeat (3) cyc(0, 1, 0, 1, 8'h00, "R4");
        repeat (3) cyc(0, 1, 1, 1, 8'h00, "R4");
        cyc(1, 1, 0, 1, 8'h00, "R4");
        repeat (3) cyc(1, 1, 1, 1, 8'h00, "R4");
        // R5 mask and global enable
        repeat (4) cyc(0, 1, 0, 1, 8'h00, "R5");
        cyc(1, 1, 2, 0, 8'h01, "R5");
        cyc(1, 1, 0, 1, 8'h00, "R5");
        cyc(1, 0, 2, 0, 8'h00, "R5");
        cyc(1, 0, 0, 1, 8'h00, "R5");
        cyc(1, 1, 0, 1, 8'h00, "R5");
        // R6 wake path
        cyc(1, 1, 2, 1, 8'h04, "R6");
        cyc(0, 1, 0, 1, 8'h00, "R6");
        cyc(1, 1, 0, 1, 8'h00, "R6");
        cyc(1, 1, 2, 0, 8'h10, "R6");
        cyc(0, 1, 0, 1, 8'h00, "R6");
        cyc(1, 1, 2, 1, 8'h00, "R6");
        cyc(1, 1, 0, 1, 8'h00, "R6");
        // R2 high-active polarity
        repeat (3) cyc(0, 1, 1, 1, 8'h00, "R2");
        cyc(1, 1, 0, 1, 8'h00, "R2");
        repeat (4) cyc(0, 1, 0, 1, 8'h00, "R2");
        cyc(0, 1, 2, 0, 8'h00, "R2");
        repeat (3) cyc(0, 1, 1, 1, 8'h00, "R2");
        // R3 mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 2);
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), op,
                1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), "R3");
        end
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule